// File: doc/BRIEF.md
# ISA Bridge Wait-State Generator

This block connects an asynchronous 68000-style CPU bus to a 16-bit ISA expansion bus. When one of two bridge chip selects is active with at least one data strobe low, it starts an ISA cycle. It turns the CPU address bits, R/W and the strobes into one ISA read or write strobe (memory or I/O), the ISA address, the byte-high-enable indication and the byte-lane steering controls. It then returns the CPU acknowledge (DTACK, active low) after a chosen number of clock cycles.

The delay is chosen by aliasing. The same 64K ISA location appears at several CPU addresses. Two address bits and a configuration pin together pick one tap of a shift register, and that shift register fills with ones while the cycle is active. Stages that are not available fall back to the last stage. A card that asserts its wait line holds the acknowledge off for as long as it needs. A controller with five named states sequences each cycle:
- IDLE: no cycle in progress.
- COUNT: the shift register is filling.
- STALL: the tap has been reached, but the card is still asserting wait.
- ACK: DTACK is driven low.
- FOREIGN: the strobes are active but no bridge chip select is asserted.

The transitions are:
- IDLE to COUNT on a bridge access.
- IDLE to FOREIGN on a non-bridge access.
- COUNT to ACK when the tap is reached and wait is clear.
- COUNT to STALL when the tap is reached and wait is set.
- STALL to ACK when wait clears.
- Any state back to IDLE at the end of a cycle.

Top module: `isa_bridge_top`

## Requirements
- R1: The strobe is decoded from index {A23, R/W}, with R/W as the low bit and R/W=1 meaning read. The four indexes map as follows: 0 = I/O write, 1 = I/O read, 2 = memory write, 3 = memory read. At most one ISA strobe is low at any time, and strobes are low only during a bridge cycle.
- R2: The ISA address is formed as follows. Bits 15:1 equal CPU address bits 15:1. Bit 0 is 1 exactly when only the lower data strobe is active.
- R3: The wait selection is the 3-bit value {gpio_sel, A22, A21}. DTACK goes low at the (tap+2)-th rising edge, counted from the first edge that sees the cycle (chip select plus a strobe). For selections 0 to 3 and 7, the tap equals the selection.
- R4: Selections 4, 5 and 6 have no stage of their own and use tap 7.
- R5: While isa_wait is high, DTACK stays high. When wait is released after the tap is reached, DTACK goes low at the first edge that sees wait low.
- R6: Once DTACK is low, it stays low for as long as the strobes and the chip select stay active.
- R7: For a transfer with the 16-bit chip select, the CPU high byte maps to the ISA high byte and the CPU low byte to the ISA low byte. sbhe_n is low exactly when the upper strobe is active. No byte swap takes place.
- R8: For a transfer with the 8-bit chip select, the bytes are steered as follows. With the upper strobe active, the CPU high byte goes to the ISA low byte. With only the lower strobe active, the CPU low byte goes to the ISA low byte. sbhe_n stays high.
- R9: An access with neither bridge chip select never drives DTACK or any ISA strobe low.
- R10: Within one clock after both strobes rise (or both chip selects rise), DTACK, all strobes, sbhe_n and the lane controls go inactive. The wait counter clears, so the next cycle counts from zero.
- R11: During reset, DTACK, all ISA strobes and sbhe_n are high and the lane controls are low.
- R12: When both chip selects are active, the 16-bit chip select wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs8_n | input | 1 | Bridge select for 8-bit transfers, active low |
| cs16_n | input | 1 | Bridge select for 16-bit transfers, active low |
| cpu_addr | input | 23 | CPU address bits 23:1 |
| gpio_sel | input | 1 | Configuration bit, top bit of the wait selection |
| isa_wait | input | 1 | Card wait request, active high |
| dtack_n | output | 1 | CPU acknowledge, active low |
| memr_n | output | 1 | ISA memory read strobe |
| memw_n | output | 1 | ISA memory write strobe |
| ior_n | output | 1 | ISA I/O read strobe |
| iow_n | output | 1 | ISA I/O write strobe |
| sbhe_n | output | 1 | ISA byte-high enable, active low |
| isa_addr | output | 16 | ISA address |
| lane_hi_hi | output | 1 | Connects the CPU high byte to the ISA high byte |
| lane_hi_lo | output | 1 | Connects the CPU high byte to the ISA low byte |
| lane_lo_lo | output | 1 | Connects the CPU low byte to the ISA low byte |

## Verification
The bench builds the block with its default parameters: an eight-stage shift register, a three-bit selection, unused selections 4 to 6 and a fallback to stage 7. With these values it can sweep every selection, including the three fallback aliases, and check the exact acknowledge edge for each one. The space bit at A23 and the wait bits at A22:A21 let it reach all four strobe decodes at the addresses the requirements name. The bench also drives card-wait releases that fall both before and after the tap is reached, so it exercises both the COUNT-to-ACK and the STALL-to-ACK transitions.

// File: rtl/isa_br_pkg.sv
package isa_br_pkg;

    typedef enum logic [2:0] {
        BR_IDLE,
        BR_COUNT,
        BR_STALL,
        BR_ACK,
        BR_FOREIGN
    } br_state_t;

    typedef struct packed {
        logic spc;   // raw space bit: 0 = I/O, 1 = memory
        logic rd;    // 1 = read
        logic wide;  // 16-bit chip select won
        logic upr;   // upper strobe active
        logic lwr;   // lower strobe active
    } br_cyc_t;

endpackage

// File: rtl/isa_ws_shift.sv
module isa_ws_shift #(
    parameter int SR_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [SR_LEN-1:0] stages
);
    // Fills with ones while a cycle runs; cleared whenever it does not.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages <= '0;
        end else if (!run) begin
            stages <= '0;
        end else begin
            stages <= {stages[SR_LEN-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/isa_ws_tapsel.sv
module isa_ws_tapsel #(
    parameter int                        SR_LEN       = 8,
    parameter int                        SEL_W        = 3,
    parameter logic [(1<<SEL_W)-1:0]     UNUSED_MASK  = 8'b0111_0000,
    parameter int                        FALLBACK_TAP = 7
) (
    input  logic [SR_LEN-1:0] stages,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);
    localparam int SEL_N = 1 << SEL_W;

    logic [SEL_N-1:0] cand;

    for (genvar g = 0; g < SEL_N; g++) begin : g_tap
        localparam bool_skip = (UNUSED_MASK[g] == 1'b1) || (g >= SR_LEN);
        localparam int TAP   = bool_skip ? FALLBACK_TAP : g;
        assign cand[g] = stages[TAP];
    end

    assign hit = cand[sel];
endmodule

// File: rtl/isa_br_decode.sv
module isa_br_decode
    import isa_br_pkg::*;
(
    input  logic    on,
    input  br_cyc_t cyc,
    output logic    memr_n,
    output logic    memw_n,
    output logic    ior_n,
    output logic    iow_n,
    output logic    sbhe_n,
    output logic    lane_hi_hi,
    output logic    lane_hi_lo,
    output logic    lane_lo_lo
);
    always_comb begin
        memr_n     = 1'b1;
        memw_n     = 1'b1;
        ior_n      = 1'b1;
        iow_n      = 1'b1;
        sbhe_n     = 1'b1;
        lane_hi_hi = 1'b0;
        lane_hi_lo = 1'b0;
        lane_lo_lo = 1'b0;
        if (on) begin
            // index {space, R/W}: R/W is the low select input
            unique case ({cyc.spc, cyc.rd})
                2'b00:   iow_n  = 1'b0;
                2'b01:   ior_n  = 1'b0;
                2'b10:   memw_n = 1'b0;
                default: memr_n = 1'b0;
            endcase
            if (cyc.wide) begin
                sbhe_n     = !cyc.upr;
                lane_hi_hi = cyc.upr;
                lane_lo_lo = cyc.lwr;
            end else begin
                lane_hi_lo = cyc.upr;
                lane_lo_lo = !cyc.upr && cyc.lwr;
            end
        end
    end
endmodule

// File: rtl/isa_bridge_top.sv
module isa_bridge_top
    import isa_br_pkg::*;
#(
    parameter int                    CPU_AW       = 24,
    parameter int                    ISA_AW       = 16,
    parameter int                    SR_LEN       = 8,
    parameter int                    SEL_W        = 3,
    parameter logic [(1<<SEL_W)-1:0] UNUSED_MASK  = 8'b0111_0000,
    parameter int                    FALLBACK_TAP = 7,
    parameter int                    SPACE_BIT    = 23,
    parameter int                    WS_LSB       = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rw,
    input  logic              cs8_n,
    input  logic              cs16_n,
    input  logic [CPU_AW-1:1] cpu_addr,
    input  logic              gpio_sel,
    input  logic              isa_wait,
    output logic              dtack_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              sbhe_n,
    output logic [ISA_AW-1:0] isa_addr,
    output logic              lane_hi_hi,
    output logic              lane_hi_lo,
    output logic              lane_lo_lo
);
    localparam int ADR_SEL_W = SEL_W - 1;

    br_state_t         state_q, state_d;
    br_cyc_t           cyc_q;
    logic [SEL_W-1:0]  sel_q;
    logic [ISA_AW-1:0] addr_q;
    logic [SR_LEN-1:0] stages;
    logic              tap_hit;
    logic              strobe_on, cs_on, cycle_on, bus_on;

    assign strobe_on = !(uds_n && lds_n);
    assign cs_on     = !(cs8_n && cs16_n);
    assign cycle_on  = strobe_on && cs_on;

    isa_ws_shift #(.SR_LEN(SR_LEN)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cycle_on),
        .stages (stages)
    );

    isa_ws_tapsel #(
        .SR_LEN       (SR_LEN),
        .SEL_W        (SEL_W),
        .UNUSED_MASK  (UNUSED_MASK),
        .FALLBACK_TAP (FALLBACK_TAP)
    ) u_tapsel (
        .stages (stages),
        .sel    (sel_q),
        .hit    (tap_hit)
    );

    // State register and cycle capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
            cyc_q   <= '0;
            sel_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BR_IDLE && cycle_on) begin
                cyc_q.spc  <= cpu_addr[SPACE_BIT];
                cyc_q.rd   <= rw;
                cyc_q.wide <= !cs16_n;
                cyc_q.upr  <= !uds_n;
                cyc_q.lwr  <= !lds_n;
                sel_q      <= {gpio_sel, cpu_addr[WS_LSB +: ADR_SEL_W]};
                addr_q     <= {cpu_addr[ISA_AW-1:1], uds_n};
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BR_IDLE: begin
                if (cycle_on)       state_d = BR_COUNT;
                else if (strobe_on) state_d = BR_FOREIGN;
            end
            BR_COUNT: begin
                if (!cycle_on)      state_d = BR_IDLE;
                else if (tap_hit)   state_d = isa_wait ? BR_STALL : BR_ACK;
            end
            BR_STALL: begin
                if (!cycle_on)      state_d = BR_IDLE;
                else if (!isa_wait) state_d = BR_ACK;
            end
            BR_ACK: begin
                if (!cycle_on)      state_d = BR_IDLE;
            end
            BR_FOREIGN: begin
                if (!strobe_on)     state_d = BR_IDLE;
            end
            default:                state_d = BR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        dtack_n = 1'b1;
        bus_on  = 1'b0;
        unique case (state_q)
            BR_COUNT, BR_STALL: bus_on = 1'b1;
            BR_ACK: begin
                bus_on  = 1'b1;
                dtack_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign isa_addr = addr_q;

    isa_br_decode u_decode (
        .on         (bus_on),
        .cyc        (cyc_q),
        .memr_n     (memr_n),
        .memw_n     (memw_n),
        .ior_n      (ior_n),
        .iow_n      (iow_n),
        .sbhe_n     (sbhe_n),
        .lane_hi_hi (lane_hi_hi),
        .lane_hi_lo (lane_hi_lo),
        .lane_lo_lo (lane_lo_lo)
    );
endmodule

// File: rtl/isa_bridge_chk.sv
module isa_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic uds_n,
    input logic lds_n,
    input logic cs8_n,
    input logic cs16_n,
    input logic isa_wait,
    input logic dtack_n,
    input logic memr_n,
    input logic memw_n,
    input logic ior_n,
    input logic iow_n,
    input logic sbhe_n,
    input logic lane_hi_hi,
    input logic lane_hi_lo,
    input logic lane_lo_lo
);
    // R1: never two ISA strobes at once
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!memr_n, !memw_n, !ior_n, !iow_n}));

    // R5: card wait keeps the acknowledge off
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack_n && isa_wait) |=> dtack_n);

    // R6: acknowledge holds while the cycle continues
    a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !(uds_n && lds_n) && !(cs8_n && cs16_n)) |=> !dtack_n);

    // R7: byte-high enable only inside an ISA strobe
    a_r7_sbhe_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !sbhe_n |-> (!memr_n || !memw_n || !ior_n || !iow_n));

    // R9: acknowledge only follows a bridge chip select
    a_r9_dtack_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> $past(!(cs8_n && cs16_n)));

    // R10: everything inactive one clock after the strobes rise
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (uds_n && lds_n) |=> (dtack_n && memr_n && memw_n && ior_n && iow_n
                              && sbhe_n && !lane_hi_hi && !lane_hi_lo && !lane_lo_lo));

    // R11: quiet outputs during reset
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (dtack_n && memr_n && memw_n && ior_n && iow_n && sbhe_n));
endmodule

bind isa_bridge_top isa_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uds_n      (uds_n),
    .lds_n      (lds_n),
    .cs8_n      (cs8_n),
    .cs16_n     (cs16_n),
    .isa_wait   (isa_wait),
    .dtack_n    (dtack_n),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .ior_n      (ior_n),
    .iow_n      (iow_n),
    .sbhe_n     (sbhe_n),
    .lane_hi_hi (lane_hi_hi),
    .lane_hi_lo (lane_hi_lo),
    .lane_lo_lo (lane_lo_lo)
);

// File: tb/tb_isa_bridge_top.sv
`timescale 1ns/1ps
module tb_isa_bridge_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic        cs8_n = 1'b1, cs16_n = 1'b1;
    logic [23:1] cpu_addr = '0;
    logic        gpio_sel = 1'b0, isa_wait = 1'b0;
    logic        dtack_n, memr_n, memw_n, ior_n, iow_n, sbhe_n;
    logic [15:0] isa_addr;
    logic        lane_hi_hi, lane_hi_lo, lane_lo_lo;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = !clk;   // 250 MHz

    isa_bridge_top dut (
        .clk(clk), .rst_n(rst_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
        .cs8_n(cs8_n), .cs16_n(cs16_n), .cpu_addr(cpu_addr),
        .gpio_sel(gpio_sel), .isa_wait(isa_wait), .dtack_n(dtack_n),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .sbhe_n(sbhe_n), .isa_addr(isa_addr), .lane_hi_hi(lane_hi_hi),
        .lane_hi_lo(lane_hi_lo), .lane_lo_lo(lane_lo_lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] quiet_vec();
        return {dtack_n, memr_n, memw_n, ior_n, iow_n};
    endfunction

    task automatic test_reset();
        @(negedge clk);
        chk(quiet_vec() == 5'h1f, "R11", "strobes in reset", quiet_vec(), 5'h1f);
        chk({sbhe_n, lane_hi_hi, lane_hi_lo, lane_lo_lo} == 4'b1000, "R11",
            "sbhe/lanes in reset", {sbhe_n, lane_hi_hi, lane_hi_lo, lane_lo_lo}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One bridge access, started and finished at a falling edge.
    task automatic access(input bit a23, input bit [2:0] sel, input bit rdv,
                          input bit w16, input bit u, input bit l,
                          input int wrel, input int hold, input string rq);
        logic [23:0] fa;
        logic [3:0]  exp_str;
        logic [15:0] exp_adr;
        logic [2:0]  exp_ln;
        int tap, exp_first, first;
        tap = (sel >= 3'd4 && sel <= 3'd6) ? 7 : int'(sel);
        exp_first = tap + 2;
        if (wrel > 0 && wrel + 1 > exp_first) exp_first = wrel + 1;
        fa = 24'h000010 | (24'(sel[1:0]) << 21) | (24'(a23) << 23) | 24'h0000a4;
        exp_str = 4'b1111;
        exp_str[3 - int'({a23, rdv} == 2'b11 ? 0 : {a23, rdv} == 2'b10 ? 1 :
                         {a23, rdv} == 2'b01 ? 2 : 3)] = 1'b0;
        exp_adr = {fa[15:1], !u};
        exp_ln  = w16 ? {u, 1'b0, l} : {1'b0, u, !u && l};

        cpu_addr = fa[23:1];
        gpio_sel = sel[2];
        rw       = rdv;
        cs16_n   = !w16;
        cs8_n    = w16;
        isa_wait = (wrel > 0);
        uds_n    = !u;
        lds_n    = !l;
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin
                chk({memr_n, memw_n, ior_n, iow_n} == exp_str, "R1", {rq, " strobe"},
                    {memr_n, memw_n, ior_n, iow_n}, exp_str);
                chk(isa_addr == exp_adr, "R2", {rq, " isa address"}, isa_addr, exp_adr);
                chk(sbhe_n == !(w16 && u), w16 ? "R7" : "R8", {rq, " sbhe"},
                    sbhe_n, !(w16 && u));
                chk({lane_hi_hi, lane_hi_lo, lane_lo_lo} == exp_ln, w16 ? "R7" : "R8",
                    {rq, " lanes"}, {lane_hi_hi, lane_hi_lo, lane_lo_lo}, exp_ln);
            end
            if (!dtack_n && first == 0) first = k;
            if (k == wrel) isa_wait = 1'b0;
            if (first != 0 && k >= first + hold) break;
        end
        chk(first == exp_first, rq, "dtack edge", first, exp_first);
        if (hold > 0)
            chk(dtack_n == 1'b0, "R6", {rq, " dtack held"}, dtack_n, 1'b0);
        uds_n = 1'b1;
        lds_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(quiet_vec() == 5'h1f && sbhe_n, "R10", {rq, " release"},
            {sbhe_n, quiet_vec()}, 6'h3f);
        cs8_n  = 1'b1;
        cs16_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_sweep();
        for (int s = 0; s < 8; s++)
            access(1'b0, 3'(s), 1'b1, 1'b1, 1'b1, 1'b1, 0, 0,
                   (s >= 4 && s <= 6) ? "R4" : "R3");
    endtask

    task automatic test_decode_lanes();
        access(1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 2, "R7");  // mem write, upper
        access(1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 0, 0, "R7");  // mem read, lower
        access(1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, "R8");  // io write 8b upper
        access(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 3, "R8");  // io write 8b lower
    endtask

    task automatic test_card_wait();
        access(1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 6, 0, "R5");  // stall path
        access(1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2, 0, "R5");  // released early
    endtask

    task automatic test_both_cs();
        cpu_addr = 23'h000020; gpio_sel = 1'b0; rw = 1'b1;
        cs8_n = 1'b0; cs16_n = 1'b0; uds_n = 1'b0; lds_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk({sbhe_n, lane_hi_hi, lane_hi_lo} == 3'b010, "R12", "16-bit wins",
            {sbhe_n, lane_hi_hi, lane_hi_lo}, 3'b010);
        uds_n = 1'b1; cs8_n = 1'b1; cs16_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic test_foreign();
        bit seen = 1'b0;
        cpu_addr = 23'h000008; rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (quiet_vec() != 5'h1f) seen = 1'b1;
        end
        chk(!seen, "R9", "no response without chip select", seen, 1'b0);
        uds_n = 1'b1; lds_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        test_reset();
        test_sweep();
        test_decode_lanes();
        test_card_wait();
        test_both_cs();
        test_foreign();
        // R10: counter restarts after foreign access
        access(1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0, "R10");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule